// File: doc/BRIEF.md
# Processor Power Mode Controller

This block keeps the power-management state of a processor core and turns it into run and enable signals for the core and for the units around it. Software writes a three-bit mode register to choose one of three low-power modes: a light mode (doze), a deeper mode (sleep) and a mode that only a reset ends (suspend). While a mode is active the core is held. The block also decides whether the tick timer and the interrupt controller keep their clock enabled, and whether the remaining units keep theirs. Pending interrupts, timer expiry events and exception entry bring the core back out of the lighter modes.

The reset input is asynchronous and active low. It asserts at once and releases through a two-stage synchronizer. The mode register can be read back at all times, so the boot code can see which mode was requested last. Clock-gate cells, voltage control and the interrupt controller itself belong to the surrounding logic.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the mode readback is 000, `core_halt` is 0, and both `tick_irq_en` and `units_en` are 1.
- R2: A cycle with `mode_wr` high loads `mode_wdata` into the register. Bit 0 is doze, bit 1 is sleep and bit 2 is suspend. The readback and the outputs show the new value after that clock edge, so the core halts in the next cycle.
- R3: With only doze active, `core_halt`=1, `tick_irq_en`=1 and `units_en`=0.
- R4: With sleep active (and suspend not active), `core_halt`=1, `tick_irq_en`=0 and `units_en`=0.
- R5: With suspend active, `core_halt`=1, `tick_irq_en`=0 and `units_en`=0.
- R6: When several mode bits are set, the effective mode is chosen in the order suspend, then sleep, then doze. That effective mode sets both the gating and the wake sources.
- R7: In effective doze, a raw `irq_pending` or a `timer_evt` sampled at a clock edge clears the doze and sleep bits at that edge. No interrupt-enable flag masks this wake.
- R8: In effective sleep, only `irq_pending` wakes the core. A `timer_evt` leaves the register unchanged.
- R9: Suspend is left only by reset. Interrupts, timer events, exception entry and writes that clear bit 2 all leave it set.
- R10: `exc_entry` clears the doze and sleep bits at the next edge. This overrides a write of those bits in the same cycle. The suspend bit is not affected.
- R11: When a write and a wake event fall in the same cycle, the written value is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 3 | Write data: bit0 doze, bit1 sleep, bit2 suspend |
| irq_pending | input | 1 | Raw interrupt pending, not masked |
| timer_evt | input | 1 | Tick timer expiry event |
| exc_entry | input | 1 | Strobe: the core is taking an exception |
| core_halt | output | 1 | Holds the core |
| tick_irq_en | output | 1 | Enable for the tick timer and the interrupt controller |
| units_en | output | 1 | Enable for all other units |
| mode_rdata | output | 3 | Mode register readback |

## Verification
The bench goes after the points where the modes differ.

- **Timer event in doze and in sleep.** A design that treats the two alike either never wakes from doze on a timer, or wakes from sleep on one.
- **Doze and sleep both set.** A wrong priority would leave the timer and interrupt controller running during sleep.
- **Suspend.** The bench throws every wake source at it, plus exception entry and a write of zero. A design that forgets the bit is sticky would resume the core.
- **Collisions in one cycle.** The bench checks a write against an exception and a write against an interrupt. These catch a wrong order of priority in the next-state logic.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int MODE_W    = 3;
  localparam int BIT_DOZE  = 0;
  localparam int BIT_SLEEP = 1;
  localparam int BIT_SUSP  = 2;

  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_DOZE    = 2'd1,
    PM_SLEEP   = 2'd2,
    PM_SUSPEND = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
  import pmc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_bits,
  output pm_state_e         state
);
  // R6: suspend outranks sleep, which outranks doze
  always_comb begin
    if (mode_bits[BIT_SUSP])       state = PM_SUSPEND;
    else if (mode_bits[BIT_SLEEP]) state = PM_SLEEP;
    else if (mode_bits[BIT_DOZE])  state = PM_DOZE;
    else                           state = PM_RUN;
  end
endmodule

// File: rtl/pmc_wake_logic.sv
module pmc_wake_logic
  import pmc_pkg::*;
(
  input  pm_state_e state,
  input  logic      irq_pending,
  input  logic      timer_evt,
  output logic      wake
);
  // R7/R8/R9: the timer wakes doze only; suspend ignores everything
  always_comb begin
    unique case (state)
      PM_DOZE:  wake = irq_pending | timer_evt;
      PM_SLEEP: wake = irq_pending;
      default:  wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmc_gate_out.sv
module pmc_gate_out
  import pmc_pkg::*;
(
  input  pm_state_e state,
  output logic      core_halt,
  output logic      tick_irq_en,
  output logic      units_en
);
  always_comb begin
    core_halt   = (state != PM_RUN);
    tick_irq_en = (state == PM_RUN) || (state == PM_DOZE);
    units_en    = (state == PM_RUN);
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              irq_pending,
  input  logic              timer_evt,
  input  logic              exc_entry,
  output logic              core_halt,
  output logic              tick_irq_en,
  output logic              units_en,
  output logic [MODE_W-1:0] mode_rdata
);
  localparam logic [MODE_W-1:0] LIGHT_MASK =
    MODE_W'((1 << BIT_DOZE) | (1 << BIT_SLEEP));

  logic              rst_sync_n;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              mode_en;
  logic              wake;
  pm_state_e         state;

  pmc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pmc_mode_decode u_dec (.mode_bits(mode_q), .state(state));

  pmc_wake_logic u_wake (
    .state(state), .irq_pending(irq_pending),
    .timer_evt(timer_evt), .wake(wake)
  );

  pmc_gate_out u_gate (
    .state(state), .core_halt(core_halt),
    .tick_irq_en(tick_irq_en), .units_en(units_en)
  );

  // Next state: write beats wake (R11), exception clears light bits
  // after the write (R10), suspend sticks (R9).
  always_comb begin
    mode_d = mode_q;
    if (mode_wr)   mode_d = mode_wdata;
    else if (wake) mode_d = mode_q & ~LIGHT_MASK;
    if (exc_entry) mode_d = mode_d & ~LIGHT_MASK;
    mode_d[BIT_SUSP] = mode_d[BIT_SUSP] | mode_q[BIT_SUSP];
  end

  assign mode_en = mode_wr | wake | exc_entry;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_rdata = mode_q;

  // Assertions
  a_r9_suspend_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q[BIT_SUSP] |=> mode_q[BIT_SUSP]);

  a_r10_exc_clears_light: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_entry |=> (mode_rdata & LIGHT_MASK) == '0);

  a_r8_sleep_ignores_timer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == PM_SLEEP && !irq_pending && !mode_wr && !exc_entry) |=> $stable(mode_q));

  a_r7_doze_wakes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == PM_DOZE && (irq_pending || timer_evt) && !mode_wr) |=> !core_halt);

  a_r4_units_off_when_halted: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_halt |-> !units_en);

  a_r5_suspend_gates_all: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_rdata[BIT_SUSP] |-> (!tick_irq_en && !units_en && core_halt));
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [2:0] mode_wdata;
  logic       irq_pending, timer_evt, exc_entry;
  logic       core_halt, tick_irq_en, units_en;
  logic [2:0] mode_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .irq_pending(irq_pending), .timer_evt(timer_evt), .exc_entry(exc_entry),
    .core_halt(core_halt), .tick_irq_en(tick_irq_en), .units_en(units_en),
    .mode_rdata(mode_rdata)
  );

  // {wr, wdata[2:0], irq, tmr, exc, exp_rd[2:0], exp_halt, exp_tick, exp_units}
  localparam int NV = 19;
  localparam logic [12:0] VEC [NV] = '{
    13'b1_001_000_001_110, // 0  R2 R3 write doze
    13'b0_000_000_001_110, // 1  R3 holds
    13'b0_000_010_000_011, // 2  R7 timer wakes doze
    13'b1_001_000_001_110, // 3  R2 doze again
    13'b0_000_100_000_011, // 4  R7 irq wakes doze
    13'b1_010_000_010_100, // 5  R4 sleep
    13'b0_000_010_010_100, // 6  R8 timer ignored
    13'b0_000_100_000_011, // 7  R8 irq wakes sleep
    13'b1_011_000_011_100, // 8  R6 sleep over doze
    13'b0_000_010_011_100, // 9  R6 timer ignored in effective sleep
    13'b0_000_001_000_011, // 10 R10 exception clears
    13'b1_010_001_000_011, // 11 R10 exception beats write
    13'b1_001_000_001_110, // 12 R2
    13'b1_010_100_010_100, // 13 R11 write beats wake
    13'b0_000_100_000_011, // 14 R8 irq wakes
    13'b1_111_000_111_100, // 15 R5 R6 suspend wins
    13'b0_000_110_111_100, // 16 R9 irq+timer ignored
    13'b0_000_001_100_100, // 17 R9 R10 exc clears light only
    13'b1_000_000_100_100  // 18 R9 write of zero ignored
  };

  function automatic string tag_of(int i);
    case (i)
      0, 3, 12: return "R2";
      1:        return "R3";
      2, 4:     return "R7";
      5:        return "R4";
      6, 7, 14: return "R8";
      8, 9:     return "R6";
      10, 11:   return "R10";
      13:       return "R11";
      15:       return "R5";
      default:  return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {rd,halt,tick,units} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {mode_rdata, core_halt, tick_irq_en, units_en};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = '0;
    irq_pending = 1'b0; timer_evt = 1'b0; exc_entry = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", outs(), 6'b000_011);          // R1 in reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", outs(), 6'b000_011);          // R1 after release

    for (int i = 0; i < NV; i++) begin
      {mode_wr, mode_wdata, irq_pending, timer_evt, exc_entry} = VEC[i][12:6];
      @(posedge clk);
      @(negedge clk);
      check(tag_of(i), outs(), VEC[i][5:0]);
    end
    mode_wr = 1'b0; mode_wdata = '0;
    irq_pending = 1'b0; timer_evt = 1'b0; exc_entry = 1'b0;

    // R9: many idle cycles with wake sources, still suspended
    irq_pending = 1'b1; timer_evt = 1'b1;
    repeat (5) @(negedge clk);
    check("R9", outs(), 6'b100_100);
    irq_pending = 1'b0; timer_evt = 1'b0;

    // R9 / R1: reset ends suspend, asynchronously
    #1 rst_n = 1'b0;
    #0.5;
    check("R9", outs(), 6'b000_011);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", outs(), 6'b000_011);

    // R2: write lands at the first edge, not before
    mode_wr = 1'b1; mode_wdata = 3'b001;
    #1;
    check("R2", outs(), 6'b000_011);
    @(negedge clk);
    mode_wr = 1'b0;
    check("R2", outs(), 6'b001_110);

    // R7: wake registered at the edge that samples the timer event
    timer_evt = 1'b1;
    #1;
    check("R7", outs(), 6'b001_110);
    @(negedge clk);
    timer_evt = 1'b0;
    check("R7", outs(), 6'b000_011);

    finish_run();
  end
endmodule